// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block turns single transfer requests from a 16-bit processor core into external bus cycles on a shared address/data bus. Each request carries an address, a read/write flag, per-byte lane enables and write data. The block then runs a four-phase cycle. In the first phase the shared bus carries the low address bits and a one-cycle address latch strobe is raised. In the remaining phases the shared bus carries data. A full-width address output, separate from the shared bus, is updated on the falling clock edge just before the cycle starts, so it leads the shared-bus address by half a clock. The pads are not modelled: every three-state output is shown as a data value paired with an output enable.

An asynchronous ready input passes through a flop synchronizer. While the synchronized ready is low, wait states are inserted between the third and fourth phases. A hold request is granted only between cycles, and the buses float for as long as the grant lasts. While reset is low, the block copies the shared-bus pins into a configuration word. It also samples a strap pin, and the value held when reset is released chooses whether the address phase on the shared bus is used.

Top module: `mux_bus_seq`

## Requirements
- R1: With ready held high, a cycle takes exactly four clocks. The strobe `ale` is high in the first of them, and `done` is high in the fourth clock after the `ale` clock.
- R2: `a_out` takes the accepted request address at the falling clock edge inside the accepting clock, which is half a clock before the first phase begins.
- R3: `ale` is high only in the first phase, for a single clock per cycle.
- R4: When the address phase is enabled, both lanes are enabled in the first phase and `ad_out` equals address bits [15:0]. When it is disabled, `ad_oe` is 2'b00 in the first phase while `ale` still pulses.
- R5: `strap_n` is sampled at the last clock edge before reset is released. A low strap gives `status_norm`=1 and enables the address phase. A high strap gives `status_norm`=0 and disables it.
- R6: In phases two to four and in wait states, a write drives `wdata` and enables lane i (`ad_oe[i]`, lane 0 = bits [7:0]) only where `req_be[i]`=1. A read enables no lane.
- R7: While reset is low or hold is granted, `a_oe` and `ad_oe` are 0. `ale` remains a driven output and is low.
- R8: `cfg_word` holds the `ad_in` value from the last clock edge before reset is released. Later changes on `ad_in` do not alter it.
- R9: `rdy_async` passes through two flops. If ready rises just after edge m of a cycle (m≥3, edge 0 entering phase one), `done` comes in clock m+4.
- R10: Read data on `ad_in` is captured at the end of phase four and appears on `rdata` in the clock where `done` is high. `done` lasts one clock.
- R11: A hold request is granted only from idle. `hlda` rises one clock after the request is seen in idle, so a request raised during a cycle waits until after phase four. `req_ready` is low while hold is requested or granted, and `hlda` drops one clock after the request is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset; while low, `ad_in` and `strap_n` are sampled |
| req_valid | input | 1 | Core requests a transfer |
| req_ready | output | 1 | Request is accepted in this clock |
| req_addr | input | 20 | Transfer address |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte lane enables |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-clock pulse after the cycle ends |
| rdata | output | 16 | Captured read data |
| hold_req | input | 1 | External bus hold request |
| hlda | output | 1 | Hold granted |
| rdy_async | input | 1 | Asynchronous ready, active high |
| strap_n | input | 1 | Address-phase / status strap |
| a_out | output | 20 | Separate address output value |
| a_oe | output | 1 | Enable for `a_out` |
| ad_out | output | 16 | Shared bus output value |
| ad_oe | output | 2 | Per-lane enables for the shared bus |
| ad_in | input | 16 | Shared bus pin value |
| ale | output | 1 | Address latch strobe |
| status_norm | output | 1 | Status pins keep their normal function |
| cfg_word | output | 16 | Configuration word captured during reset |

## Verification
The first phase starts one rising edge after a request is accepted. The next three phases follow at one clock each, and `done`, with its read data, comes one clock after phase four. With ready held low, the ready rise takes two extra edges to cross the synchronizer, and one more edge moves the cycle to phase four. The separate address moves at the falling edge, so it is checked late in the accepting clock, before the first phase. All other outputs are checked just after each rising edge, and the bench counts clocks from the `ale` clock to compare against these fixed positions. Hold grant, configuration capture and strap decode are each checked one clock after the edge that should produce them.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_T1   = 3'd1,
      ST_T2   = 3'd2,
      ST_T3   = 3'd3,
      ST_TW   = 3'd4,
      ST_T4   = 3'd5,
      ST_HOLD = 3'd6
   } bus_state_e;
endpackage

// File: rtl/mbus_rdy_sync.sv
module mbus_rdy_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mbus_rdy_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= 1'b0;
         else if (s == 0) chain[s] <= async_in;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/mbus_cfg_cap.sv
module mbus_cfg_cap #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] pins_in,
   input  logic          strap_n,
   output logic [DW-1:0] cfg_word,
   output logic          strap_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_word <= pins_in;
         strap_q  <= strap_n;
      end
   end

   assert_cfg_stable_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ($stable(cfg_word) && $stable(strap_q)));
endmodule

// File: rtl/mbus_cycle_fsm.sv
module mbus_cycle_fsm
   import mbus_pkg::*;
#(
   parameter int AW = 20,
   parameter int DW = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_valid,
   input  logic [AW-1:0]  req_addr,
   input  logic           req_wr,
   input  logic [DW/8-1:0] req_be,
   input  logic [DW-1:0]  req_wdata,
   input  logic           hold_req,
   input  logic           rdy_s,
   input  logic [DW-1:0]  ad_in,
   output bus_state_e     state,
   output logic [DW-1:0]  cur_lo,
   output logic           cur_wr,
   output logic [DW/8-1:0] cur_be,
   output logic [DW-1:0]  cur_wdata,
   output logic [AW-1:0]  a_early,
   output logic           req_ready,
   output logic           done,
   output logic [DW-1:0]  rdata
);
   bus_state_e nxt;
   logic       start;

   assign req_ready = (state == ST_IDLE) && !hold_req;
   assign start     = req_ready && req_valid;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: begin
            if (hold_req)       nxt = ST_HOLD;
            else if (req_valid) nxt = ST_T1;
         end
         ST_T1:   nxt = ST_T2;
         ST_T2:   nxt = ST_T3;
         ST_T3,
         ST_TW:   nxt = rdy_s ? ST_T4 : ST_TW;
         ST_T4:   nxt = ST_IDLE;
         ST_HOLD: nxt = hold_req ? ST_HOLD : ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cur_lo    <= '0;
         cur_wr    <= 1'b0;
         cur_be    <= '0;
         cur_wdata <= '0;
         done      <= 1'b0;
         rdata     <= '0;
      end else begin
         state <= nxt;
         done  <= (state == ST_T4);
         if (start) begin
            cur_lo    <= req_addr[DW-1:0];
            cur_wr    <= req_wr;
            cur_be    <= req_be;
            cur_wdata <= req_wdata;
         end
         if (state == ST_T4 && !cur_wr) rdata <= ad_in;
      end
   end

   // separate address moves half a clock ahead of the first phase
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)     a_early <= '0;
      else if (start) a_early <= req_addr;
   end

   assert_wait_on_low_ready_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_T3 || state == ST_TW) && !rdy_s) |=> (state == ST_TW));
   assert_hold_from_idle_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD) |-> ($past(state) == ST_IDLE || $past(state) == ST_HOLD));
   assert_done_single_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_four_phase_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_T1) |=> (state == ST_T2));
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
   import mbus_pkg::*;
#(
   parameter int AW          = 20,
   parameter int DW          = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [AW-1:0]   req_addr,
   input  logic            req_wr,
   input  logic [DW/8-1:0] req_be,
   input  logic [DW-1:0]   req_wdata,
   output logic            done,
   output logic [DW-1:0]   rdata,
   input  logic            hold_req,
   output logic            hlda,
   input  logic            rdy_async,
   input  logic            strap_n,
   output logic [AW-1:0]   a_out,
   output logic            a_oe,
   output logic [DW-1:0]   ad_out,
   output logic [DW/8-1:0] ad_oe,
   input  logic [DW-1:0]   ad_in,
   output logic            ale,
   output logic            status_norm,
   output logic [DW-1:0]   cfg_word
);
   localparam int NL = DW / 8;

   if (DW % 8 != 0 || DW < 8) begin : g_bad_dw
      $error("mux_bus_seq: DW must be a nonzero multiple of 8");
   end
   if (AW < DW) begin : g_bad_aw
      $error("mux_bus_seq: AW must not be narrower than DW");
   end

   bus_state_e          state;
   logic [DW-1:0]       cur_lo;
   logic                cur_wr;
   logic [NL-1:0]       cur_be;
   logic [DW-1:0]       cur_wdata;
   logic                rdy_s;
   logic                strap_q;
   logic                addr_en;
   logic                data_ph;

   mbus_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (rdy_async),
      .sync_out (rdy_s)
   );

   mbus_cfg_cap #(.DW(DW)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .pins_in  (ad_in),
      .strap_n  (strap_n),
      .cfg_word (cfg_word),
      .strap_q  (strap_q)
   );

   mbus_cycle_fsm #(.AW(AW), .DW(DW)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .req_wr    (req_wr),
      .req_be    (req_be),
      .req_wdata (req_wdata),
      .hold_req  (hold_req),
      .rdy_s     (rdy_s),
      .ad_in     (ad_in),
      .state     (state),
      .cur_lo    (cur_lo),
      .cur_wr    (cur_wr),
      .cur_be    (cur_be),
      .cur_wdata (cur_wdata),
      .a_early   (a_out),
      .req_ready (req_ready),
      .done      (done),
      .rdata     (rdata)
   );

   assign status_norm = !strap_q;
   assign addr_en     = !strap_q;
   assign hlda        = (state == ST_HOLD);
   assign a_oe        = rst_n && (state != ST_HOLD);
   assign ale         = (state == ST_T1);
   assign data_ph     = (state == ST_T2) || (state == ST_T3) ||
                        (state == ST_TW) || (state == ST_T4);

   for (genvar g = 0; g < NL; g++) begin : g_lane
      logic       lane_oe;
      logic [7:0] lane_dat;
      always_comb begin
         lane_oe  = 1'b0;
         lane_dat = cur_wdata[g*8 +: 8];
         if (ale) begin
            lane_oe  = addr_en;
            lane_dat = cur_lo[g*8 +: 8];
         end else if (data_ph) begin
            lane_oe  = cur_wr && cur_be[g];
         end
      end
      assign ad_out[g*8 +: 8] = lane_dat;
      assign ad_oe[g]         = lane_oe && rst_n;
   end

   assert_float_in_hold_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      hlda |-> (!a_oe && ad_oe == '0 && !ale));
   assert_ale_single_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale);
   assert_addr_match_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (ale && ad_oe != '0) |-> (ad_out == a_out[DW-1:0]));
   assert_read_floats_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (data_ph && !cur_wr) |-> (ad_oe == '0));
endmodule

// File: tb/tb_mux_bus_seq.sv
module tb_mux_bus_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [19:0] req_addr = '0;
   logic        req_wr = 1'b0;
   logic [1:0]  req_be = '0;
   logic [15:0] req_wdata = '0;
   logic        done;
   logic [15:0] rdata;
   logic        hold_req = 1'b0;
   logic        hlda;
   logic        rdy_async = 1'b1;
   logic        strap_n = 1'b0;
   logic [19:0] a_out;
   logic        a_oe;
   logic [15:0] ad_out;
   logic [1:0]  ad_oe;
   logic [15:0] ad_in = '0;
   logic        ale;
   logic        status_norm;
   logic [15:0] cfg_word;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   mux_bus_seq dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_wr(req_wr), .req_be(req_be), .req_wdata(req_wdata),
      .done(done), .rdata(rdata), .hold_req(hold_req), .hlda(hlda),
      .rdy_async(rdy_async), .strap_n(strap_n), .a_out(a_out), .a_oe(a_oe),
      .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale),
      .status_norm(status_norm), .cfg_word(cfg_word)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", req, $time, act, exp);
      end
   endtask

   task automatic nxt();
      @(posedge clk);
      #2;
   endtask

   task automatic do_reset(input logic strap, input logic [15:0] cfgval);
      rst_n = 1'b0; strap_n = strap; ad_in = cfgval;
      repeat (4) nxt();
      chk(a_oe == 1'b0, "R7 reset a_oe", a_oe, 0);
      chk(ad_oe == 2'b00, "R7 reset ad_oe", ad_oe, 0);
      chk(ale == 1'b0, "R7 reset ale", ale, 0);
      rst_n = 1'b1;
      ad_in = ~cfgval; strap_n = ~strap;
      repeat (2) nxt();
      chk(cfg_word == cfgval, "R8 cfg capture", cfg_word, cfgval);
      chk(status_norm == !strap, "R5 strap decode", status_norm, !strap);
      chk(a_oe == 1'b1 && hlda == 1'b0, "R7 after reset", {a_oe, hlda}, 2'b10);
   endtask

   // m < 0: ready stays high; otherwise ready rises just after edge m
   task automatic run_cycle(input logic [19:0] addr, input logic wr, input logic [1:0] be,
                            input logic [15:0] wd, input logic [15:0] rd_val,
                            input int m, input logic aphase);
      int n;
      int done_at;
      int exp_done;
      logic [1:0] exp_oe;
      ad_in = rd_val; req_addr = addr; req_wr = wr; req_be = be; req_wdata = wd;
      req_valid = 1'b1;
      chk(req_ready == 1'b1, "R11 idle accepts", req_ready, 1);
      #13;
      chk(a_out == addr, "R2 early address", a_out, addr);
      chk(ale == 1'b0, "R3 no strobe before T1", ale, 0);
      nxt();
      req_valid = 1'b0;
      chk(ale == 1'b1, "R3 strobe in T1", ale, 1);
      if (aphase)
         chk(ad_oe == 2'b11 && ad_out == addr[15:0], "R4 address phase", {ad_oe, ad_out}, {2'b11, addr[15:0]});
      else
         chk(ad_oe == 2'b00, "R4 address phase off", ad_oe, 0);
      exp_oe   = wr ? be : 2'b00;
      exp_done = (m < 0) ? 4 : m + 4;
      done_at  = -1;
      n = 0;
      while (done_at < 0 && n < 40) begin
         nxt();
         n++;
         if (n == m) rdy_async = 1'b1;
         if (done) done_at = n;
         else begin
            if (ale) chk(1'b0, "R3 strobe outside T1", ale, 0);
            if (ad_oe != exp_oe) chk(1'b0, "R6 lane enables", ad_oe, exp_oe);
            if (wr && ad_out != wd) chk(1'b0, "R6 write data", ad_out, wd);
         end
      end
      chk(done_at == exp_done, (m < 0) ? "R1 cycle length" : "R9 wait states", done_at, exp_done);
      if (!wr) chk(rdata == rd_val, "R10 read data", rdata, rd_val);
      nxt();
      chk(done == 1'b0, "R10 done one clock", done, 0);
   endtask

   task automatic t_wait_states();
      rdy_async = 1'b0;
      repeat (3) nxt();
      run_cycle(20'h3_0010, 1'b0, 2'b11, 16'h0, 16'hBEEF, 6, 1'b1);
   endtask

   task automatic t_hold_idle();
      hold_req = 1'b1;
      nxt();
      chk(hlda == 1'b1, "R11 hold grant", hlda, 1);
      chk(a_oe == 1'b0 && ad_oe == 2'b00, "R7 hold floats", {a_oe, ad_oe}, 0);
      chk(ale == 1'b0, "R7 ale low in hold", ale, 0);
      chk(req_ready == 1'b0, "R11 no accept in hold", req_ready, 0);
      nxt();
      chk(hlda == 1'b1, "R11 hold kept", hlda, 1);
      hold_req = 1'b0;
      nxt();
      chk(hlda == 1'b0 && a_oe == 1'b1, "R11 hold release", {hlda, a_oe}, 2'b01);
   endtask

   task automatic t_hold_mid_cycle();
      logic late_bad;
      ad_in = 16'h1357; req_addr = 20'h0_4444; req_wr = 1'b0; req_be = 2'b11;
      req_valid = 1'b1;
      nxt();
      req_valid = 1'b0;
      late_bad = 1'b0;
      for (int k = 1; k <= 4; k++) begin
         nxt();
         if (k == 1) hold_req = 1'b1;
         if (hlda) late_bad = 1'b1;
         if (k == 4) chk(done == 1'b1, "R11 cycle completes under hold", done, 1);
      end
      chk(!late_bad, "R11 no grant mid cycle", late_bad, 0);
      nxt();
      chk(hlda == 1'b1, "R11 grant after T4", hlda, 1);
      hold_req = 1'b0;
      nxt();
      chk(hlda == 1'b0, "R11 released", hlda, 0);
   endtask

   initial begin : watchdog
      #(20 * 100000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      do_reset(1'b0, 16'hA5C3);
      run_cycle(20'hA_1234, 1'b1, 2'b11, 16'hC0DE, 16'h0, -1, 1'b1);
      run_cycle(20'h5_5AA4, 1'b1, 2'b01, 16'h00F1, 16'h0, -1, 1'b1);
      run_cycle(20'h0_0FFE, 1'b1, 2'b10, 16'h7700, 16'h0, -1, 1'b1);
      run_cycle(20'hF_FFF0, 1'b0, 2'b11, 16'h0, 16'h9A3C, -1, 1'b1);
      t_wait_states();
      t_hold_idle();
      t_hold_mid_cycle();
      do_reset(1'b1, 16'h0F69);
      run_cycle(20'h2_8642, 1'b1, 2'b11, 16'h4321, 16'h0, -1, 1'b0);
      run_cycle(20'h7_0002, 1'b0, 2'b11, 16'h0, 16'h2468, -1, 1'b0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule